// File: doc/BRIEF.md
# Ramp Sequencer with Blanking

This block produces the digital code for a sawtooth sweep. A 12-bit counter advances once per clock. During the first 4000 states of its 4096-state cycle, the counter value goes straight to a parallel DAC word, so the analog output rises in even steps. During the last 96 states the code is held at zero and an active-high blanking flag is raised. The swept instrument uses that interval to return to its start point, and a display can use the same flag to dim its beam.

The block has two operating modes. In free-running mode the counter wraps and the sweep repeats without a break. In triggered mode the sequencer spends one clock in blanking, then clears its counter and waits with a zero code until an external trigger arrives. The trigger is asynchronous: it is synchronized and edge-detected before it is used. A change of mode is taken in only at the end of a ramp, so a sweep that is in progress always finishes.

Top module: `ramp_sequencer`

## Requirements
- R1: While `rst_n` is low (asserted asynchronously), `dac_code` is 0, and `blank` and `waiting` are low while `ramp_active` is high. After release, the code reads 1 within at most four clock edges and then counts up from there.
- R2: For counter states 0 to 3999, `dac_code` equals the counter value and `ramp_active` is high. The counter advances by one on each clock.
- R3: For counter states 4000 to 4095, `dac_code` is 0, `blank` is high and `ramp_active` is low.
- R4: In free-running mode (`trig_mode` = 0), the counter moves from 4095 to 0 and a new ramp starts at once.
- R5: In triggered mode (`trig_mode` = 1), the cycle that enters blanking (state 4000) is the only blanking cycle. The clock edge after it clears the counter and enters the hold.
- R6: During the hold, `waiting` is high, `dac_code` is 0, and `blank` and `ramp_active` are low.
- R7: A rising edge on `ext_trig` passes through a two-flop synchronizer. If the input rises before clock edge k while the block is in hold, edge k+2 ends the hold with the code at 0, and the code reads 1 after edge k+3.
- R8: A trigger edge that reaches the sequencer while it is not in hold has no effect. This includes an edge that lands in the cycle that enters blanking.
- R9: `trig_mode` is sampled only at counter state 3999 while a ramp is running. A change made in the middle of a ramp neither shortens nor stops that ramp.
- R10: While in hold, `trig_mode` = 0 ends the hold on the next clock, and the free-running ramp starts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, one counter step per edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through two flops |
| trig_mode | input | 1 | 0 = free-running, 1 = triggered |
| ext_trig | input | 1 | Asynchronous trigger; its rising edge ends the hold |
| dac_code | output | 12 | Parallel code for the DAC |
| blank | output | 1 | High during the zero-code tail of a running cycle |
| ramp_active | output | 1 | High while the code follows the counter |
| waiting | output | 1 | High while holding for a trigger |

## Verification
A synchronized trigger edge can reach the sequencer in the same cycle that it enters blanking in triggered mode. In that cycle, entering the hold and releasing it compete. The bench raises `ext_trig` when the code reads 3998. This places the detected edge on counter state 4000. The bench then requires `waiting` to go high and to stay high for several cycles afterwards. A second overlap, a mode change in the middle of a ramp, is judged by whether that ramp still reaches 3999 before the new mode takes effect.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } seq_state_t;

  typedef enum logic {
    MODE_FREE = 1'b0,
    MODE_TRIG = 1'b1
  } seq_mode_t;
endpackage

// File: rtl/ramp_trig_sync.sv
module ramp_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic trig_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], trig_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign trig_rise = sync_q[SYNC_STAGES-1] & ~last_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise); // R7
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter
  import ramp_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int RAMP_LEN = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_in,
  input  logic             trig_rise,
  output logic [CNT_W-1:0] cnt_o,
  output seq_state_t       state_o
);
  localparam logic [CNT_W-1:0] LAST_RAMP = CNT_W'(RAMP_LEN - 1);
  localparam logic [CNT_W-1:0] BLANK_1ST = CNT_W'(RAMP_LEN);
  localparam logic [CNT_W-1:0] CNT_TOP   = {CNT_W{1'b1}};

  seq_state_t       state_q, state_d;
  seq_mode_t        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_RUN: begin
        if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == LAST_RAMP) mode_d = seq_mode_t'(mode_in);
        if (cnt_q == BLANK_1ST && mode_q == MODE_TRIG) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end
      end
      ST_HOLD: begin
        mode_d = seq_mode_t'(mode_in);
        cnt_d  = '0;
        if (trig_rise || !mode_in) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mode_q  <= MODE_FREE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign state_o = state_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != '0) |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q == CNT_TOP) |=> (state_q == ST_RUN && cnt_q == '0)); // R4
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q == BLANK_1ST && mode_q == MODE_TRIG)
      |=> (state_q == ST_HOLD && cnt_q == '0)); // R5
  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && trig_rise && cnt_q != BLANK_1ST) |=> state_q == ST_RUN); // R8
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != LAST_RAMP) |=> $stable(mode_q)); // R9
endmodule

// File: rtl/ramp_decode.sv
module ramp_decode
  import ramp_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int RAMP_LEN = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  seq_state_t       state_i,
  output logic [CNT_W-1:0] code_o,
  output logic             blank_o,
  output logic             active_o,
  output logic             wait_o
);
  localparam logic [CNT_W-1:0] BLANK_1ST = CNT_W'(RAMP_LEN);

  logic running;
  logic in_ramp;

  always_comb begin
    running  = (state_i == ST_RUN);
    in_ramp  = (cnt_i < BLANK_1ST);
    active_o = running & in_ramp;
    blank_o  = running & ~in_ramp;
    wait_o   = ~running;
    code_o   = active_o ? cnt_i : '0;
  end

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> (code_o == '0 && !active_o)); // R3
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> (code_o == '0 && !blank_o && !active_o)); // R6
endmodule

// File: rtl/ramp_sequencer.sv
module ramp_sequencer
  import ramp_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int RAMP_LEN    = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_mode,
  input  logic             ext_trig,
  output logic [CNT_W-1:0] dac_code,
  output logic             blank,
  output logic             ramp_active,
  output logic             waiting
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             trig_rise;
  logic [CNT_W-1:0] cnt;
  seq_state_t       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ramp_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .trig_async (ext_trig),
    .trig_rise  (trig_rise)
  );

  ramp_counter #(.CNT_W(CNT_W), .RAMP_LEN(RAMP_LEN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode_in   (trig_mode),
    .trig_rise (trig_rise),
    .cnt_o     (cnt),
    .state_o   (state)
  );

  ramp_decode #(.CNT_W(CNT_W), .RAMP_LEN(RAMP_LEN)) u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cnt_i    (cnt),
    .state_i  (state),
    .code_o   (dac_code),
    .blank_o  (blank),
    .active_o (ramp_active),
    .wait_o   (waiting)
  );
endmodule

// File: tb/ramp_sequencer_test.sv
module ramp_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_mode;
  logic        ext_trig;
  logic [11:0] dac_code;
  logic        blank, ramp_active, waiting;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ramp_sequencer uut (
    .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .ext_trig(ext_trig),
    .dac_code(dac_code), .blank(blank), .ramp_active(ramp_active), .waiting(waiting)
  );

  // {offset from first code 1, code, blank, active}
  localparam int NVEC = 11;
  localparam logic [29:0] VEC_TBL [0:NVEC-1] = '{
    {16'd0,    12'd1,    1'b0, 1'b1},
    {16'd1,    12'd2,    1'b0, 1'b1},
    {16'd499,  12'd500,  1'b0, 1'b1},
    {16'd3997, 12'd3998, 1'b0, 1'b1},
    {16'd3998, 12'd3999, 1'b0, 1'b1},
    {16'd3999, 12'd0,    1'b1, 1'b0},
    {16'd4000, 12'd0,    1'b1, 1'b0},
    {16'd4094, 12'd0,    1'b1, 1'b0},
    {16'd4095, 12'd0,    1'b0, 1'b1},
    {16'd4096, 12'd1,    1'b0, 1'b1},
    {16'd5000, 12'd905,  1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_code(input int code, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (int'(dac_code) == code) return;
      @(negedge clk);
    end
    check(1'b0, "wait for code", int'(dac_code), code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int pos;
    int v;
    rst_n = 1'b0; trig_mode = 1'b0; ext_trig = 1'b0;
    step(3);
    // R1 reset state
    check(dac_code == 0 && !blank && !waiting && ramp_active, "R1 reset outputs",
          {dac_code, blank, ramp_active, waiting}, 1 << 1);
    rst_n = 1'b1;
    step(1);
    wait_code(1, 6);

    // R2 R3 R4 free-running vector walk
    pos = 0;
    for (int k = 0; k < NVEC; k++) begin
      while (pos < int'(VEC_TBL[k][29:14])) begin step(1); pos++; end
      check(dac_code == VEC_TBL[k][13:2] && blank == VEC_TBL[k][1] &&
            ramp_active == VEC_TBL[k][0] && !waiting,
            $sformatf("R2/R3/R4 vector %0d", k),
            {dac_code, blank, ramp_active, waiting}, {VEC_TBL[k][13:0], 1'b0});
    end

    // R9: switch to triggered mode mid-ramp; R8: trigger during ramp ignored
    trig_mode = 1'b1;
    step(1);
    v = int'(dac_code);
    ext_trig = 1'b1; step(3); ext_trig = 1'b0; step(5);
    check(int'(dac_code) == v + 8 && !waiting, "R8 trigger mid-ramp", int'(dac_code), v + 8);
    wait_code(3999, 4096);
    check(int'(dac_code) == 3999, "R9 ramp not truncated", int'(dac_code), 3999);
    step(1);
    check(blank && dac_code == 0 && !waiting, "R5 single blank cycle", blank, 1);
    step(1);
    check(waiting && !blank && !ramp_active && dac_code == 0, "R5/R6 hold entered",
          {dac_code, blank, ramp_active, waiting}, 1);
    step(30);
    check(waiting && dac_code == 0 && !blank, "R6 hold persists", waiting, 1);

    // R7 trigger release latency
    ext_trig = 1'b1;
    step(2);
    check(waiting, "R7 still holding after two edges", waiting, 1);
    step(1);
    check(!waiting && ramp_active && dac_code == 0, "R7 released at third edge",
          {dac_code, ramp_active, waiting}, 2);
    step(1);
    check(dac_code == 1, "R7 code follows release", int'(dac_code), 1);
    ext_trig = 1'b0;

    // R8: trigger edge coinciding with entry into blanking
    wait_code(3998, 4096);
    ext_trig = 1'b1;
    step(2);
    check(blank && !waiting, "R8 blank entry cycle", blank, 1);
    step(1);
    check(waiting, "R8 coincident edge ignored", waiting, 1);
    step(2); ext_trig = 1'b0; step(5);
    check(waiting && dac_code == 0, "R8 hold kept", waiting, 1);

    // R10 leave hold by selecting free-running
    trig_mode = 1'b0;
    step(1);
    check(!waiting && ramp_active && dac_code == 0, "R10 hold released", waiting, 0);
    step(1);
    check(dac_code == 1, "R10 counting resumes", int'(dac_code), 1);

    // R4 free-running wrap after full blanking tail
    wait_code(3999, 4096);
    step(1);
    check(blank && !waiting, "R4 tail start", blank, 1);
    step(95);
    check(blank && !waiting && dac_code == 0, "R4 tail end", blank, 1);
    step(1);
    check(ramp_active && !blank && !waiting && dac_code == 0, "R4 wrap to zero",
          {dac_code, blank, ramp_active, waiting}, 2);

    // R1 asynchronous reset mid-ramp
    step(20);
    #1 rst_n = 1'b0;
    #1;
    check(dac_code == 0 && !blank && !waiting && ramp_active, "R1 async reset",
          int'(dac_code), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule